// File: doc/BRIEF.md
# Stub Level-2 Cache Controller Register Bank

This block occupies the register window of a level-2 cache controller in a system that has no real second-level cache. Boot and driver software can probe, configure and maintain the cache through it as usual: identification and type registers read back credible values, configuration registers hold what is written and come out of reset with sensible defaults, and every maintenance operation reads as already complete. No data, tags or lines are stored anywhere.

Accesses arrive on a simple single-cycle bus. A request strobe comes with a write flag, a byte address and write data. Read data is registered and appears on the cycle after a read. A one-cycle error pulse marks any access to an offset the bank does not implement. Only the low twelve address bits are decoded, so the 4 KiB window repeats across whatever larger region the bank is mapped into.

The type register is more than a constant. It starts from a parameter. On every read, a field derived from the auxiliary control register is ORed into it and the result is kept, so bits that have once been set stay set.

Top module: `cstub_regbank`

## Requirements
- R1: After reset, auxiliary control (0x104) reads 0x02020000. Control (0x100), tag RAM control (0x108), data RAM control (0x10C), filter start (0xC00) and filter end (0xC04) read zero.
- R2: Offset 0x000 always reads the identification value 0x410000C8, and writes to it change nothing.
- R3: Only acc_addr[11:0] is decoded. Addresses that differ only above bit 11 reach the same register.
- R4: A write to control (0x100) stores only wdata bit 0. Bits 31:1 of control always read zero.
- R5: Auxiliary control (0x104), tag RAM control (0x108) and data RAM control (0x10C) store and return all 32 written bits.
- R6: Filter start (0xC00) and filter end (0xC04) store and return all 32 written bits.
- R7: A read of 0x004 forms f = {aux[19:17], 1'b0, aux[16]} and ORs (f << 18) | (f << 6) into the stored type register, which starts at TYPE_INIT. The read returns the updated value and keeps it, so set bits stay set. Writes to 0x004 change nothing.
- R8: Every offset from 0x730 up to but not including 0x800 reads zero, ignores writes and raises no error.
- R9: Offsets 0xF40, 0xF60 and 0xF80 read zero, ignore writes and raise no error.
- R10: Any other offset, including one that is not word-aligned, reads zero and ignores writes. acc_err is high in the same cycle as such an access, whether read or write, and acc_err is never high without acc_en.
- R11: acc_rdata carries the result of a read in the cycle after that read. In the cycle after a write or an idle cycle it is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address; only bits 11:0 are decoded |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data, valid the cycle after a read |
| acc_err | output | 1 | Pulse in the access cycle for an unimplemented offset |

## Verification
The bench builds the bank with ADDR_W = 16 and the default TYPE_INIT, ID and reset parameters. This keeps the whole 12-bit offset space small enough to sweep exhaustively. Every offset, aligned or not, is read straight after reset, written with a distinct pattern through an aliased upper address, and read back through a different alias. Each returned word and each error bit is compared against a behavioural model kept in the bench. Targeted accesses then drive chosen auxiliary values, so the sticky OR behaviour of the type register can be seen across repeated reads and after the auxiliary field is cleared.

// File: rtl/cstub_pkg.sv
package cstub_pkg;

  localparam int DATA_W = 32;
  localparam int OFF_W  = 12;

  typedef enum logic [3:0] {
    SEL_ID,
    SEL_TYPE,
    SEL_CTRL,
    SEL_AUX,
    SEL_TAGC,
    SEL_DATAC,
    SEL_FSTART,
    SEL_FEND,
    SEL_MAINT,
    SEL_QUIET,
    SEL_BAD
  } sel_e;

  localparam logic [OFF_W-1:0] OFF_ID     = 12'h000;
  localparam logic [OFF_W-1:0] OFF_TYPE   = 12'h004;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 12'h100;
  localparam logic [OFF_W-1:0] OFF_AUX    = 12'h104;
  localparam logic [OFF_W-1:0] OFF_TAGC   = 12'h108;
  localparam logic [OFF_W-1:0] OFF_DATAC  = 12'h10C;
  localparam logic [OFF_W-1:0] OFF_FSTART = 12'hC00;
  localparam logic [OFF_W-1:0] OFF_FEND   = 12'hC04;
  localparam logic [OFF_W-1:0] OFF_QUIET0 = 12'hF40;
  localparam logic [OFF_W-1:0] OFF_QUIET1 = 12'hF60;
  localparam logic [OFF_W-1:0] OFF_QUIET2 = 12'hF80;
  localparam logic [OFF_W-1:0] MAINT_LO   = 12'h730;
  localparam logic [OFF_W-1:0] MAINT_HI   = 12'h800;

  // Number of full-width writable configuration registers
  localparam int NCFG = 5;

  // Fold of auxiliary control into the type register
  function automatic logic [DATA_W-1:0] type_fold(input logic [DATA_W-1:0] aux);
    logic [4:0] f;
    f = {aux[19:17], 1'b0, aux[16]};
    return (DATA_W'(f) << 18) | (DATA_W'(f) << 6);
  endfunction

endpackage

// File: rtl/cstub_decode.sv
module cstub_decode
  import cstub_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  output sel_e             sel
);

  always_comb begin
    if (off >= MAINT_LO && off < MAINT_HI) begin
      sel = SEL_MAINT;
    end else begin
      unique case (off)
        OFF_ID:     sel = SEL_ID;
        OFF_TYPE:   sel = SEL_TYPE;
        OFF_CTRL:   sel = SEL_CTRL;
        OFF_AUX:    sel = SEL_AUX;
        OFF_TAGC:   sel = SEL_TAGC;
        OFF_DATAC:  sel = SEL_DATAC;
        OFF_FSTART: sel = SEL_FSTART;
        OFF_FEND:   sel = SEL_FEND;
        OFF_QUIET0,
        OFF_QUIET1,
        OFF_QUIET2: sel = SEL_QUIET;
        default:    sel = SEL_BAD;
      endcase
    end
  end

endmodule

// File: rtl/cstub_cfg_regs.sv
module cstub_cfg_regs
  import cstub_pkg::*;
#(
  parameter logic [DATA_W-1:0] AUX_RESET = 32'h0202_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              ctrl_en,
  output logic [DATA_W-1:0] aux,
  output logic [DATA_W-1:0] tagc,
  output logic [DATA_W-1:0] datac,
  output logic [DATA_W-1:0] fstart,
  output logic [DATA_W-1:0] fend
);

  // Slot order: aux, tag control, data control, filter start, filter end
  localparam sel_e SLOT_SEL [NCFG] = '{SEL_AUX, SEL_TAGC, SEL_DATAC, SEL_FSTART, SEL_FEND};

  logic [DATA_W-1:0] cfg_q [NCFG];

  for (genvar i = 0; i < NCFG; i++) begin : g_slot
    localparam logic [DATA_W-1:0] RST_VAL = (i == 0) ? AUX_RESET : '0;
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[i] <= RST_VAL;
      end else if (wr_en && sel == SLOT_SEL[i]) begin
        cfg_q[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en <= 1'b0;
    end else if (wr_en && sel == SEL_CTRL) begin
      ctrl_en <= wdata[0];
    end
  end

  assign aux    = cfg_q[0];
  assign tagc   = cfg_q[1];
  assign datac  = cfg_q[2];
  assign fstart = cfg_q[3];
  assign fend   = cfg_q[4];

endmodule

// File: rtl/cstub_type_reg.sv
module cstub_type_reg
  import cstub_pkg::*;
#(
  parameter logic [DATA_W-1:0] TYPE_INIT = 32'h1C10_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_type,
  input  logic [DATA_W-1:0] aux,
  output logic [DATA_W-1:0] type_next
);

  logic [DATA_W-1:0] type_q;

  assign type_next = type_q | type_fold(aux);

  always_ff @(posedge clk) begin
    if (rst) begin
      type_q <= TYPE_INIT;
    end else if (rd_type) begin
      type_q <= type_next;
    end
  end

endmodule

// File: rtl/cstub_regbank.sv
module cstub_regbank
  import cstub_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [DATA_W-1:0] ID_VALUE  = 32'h4100_00C8,
  parameter logic [DATA_W-1:0] TYPE_INIT = 32'h1C10_0100,
  parameter logic [DATA_W-1:0] AUX_RESET = 32'h0202_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              acc_err
);

  logic [OFF_W-1:0]  off;
  logic              unused_hi;
  sel_e              sel;
  logic              rd_en, wr_en;
  logic              ctrl_en;
  logic [DATA_W-1:0] aux, tagc, datac, fstart, fend, type_next;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign off       = acc_addr[OFF_W-1:0];
  assign unused_hi = ^acc_addr[ADDR_W-1:OFF_W];
  assign rd_en     = acc_en && !acc_wr;
  assign wr_en     = acc_en && acc_wr;

  cstub_decode u_decode (
    .off (off),
    .sel (sel)
  );

  cstub_cfg_regs #(.AUX_RESET(AUX_RESET)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .sel     (sel),
    .wdata   (acc_wdata),
    .ctrl_en (ctrl_en),
    .aux     (aux),
    .tagc    (tagc),
    .datac   (datac),
    .fstart  (fstart),
    .fend    (fend)
  );

  cstub_type_reg #(.TYPE_INIT(TYPE_INIT)) u_type (
    .clk       (clk),
    .rst       (rst),
    .rd_type   (rd_en && sel == SEL_TYPE),
    .aux       (aux),
    .type_next (type_next)
  );

  always_comb begin
    unique case (sel)
      SEL_ID:     rd_mux = ID_VALUE;
      SEL_TYPE:   rd_mux = type_next;
      SEL_CTRL:   rd_mux = {{(DATA_W-1){1'b0}}, ctrl_en};
      SEL_AUX:    rd_mux = aux;
      SEL_TAGC:   rd_mux = tagc;
      SEL_DATAC:  rd_mux = datac;
      SEL_FSTART: rd_mux = fstart;
      SEL_FEND:   rd_mux = fend;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_en ? rd_mux : '0;
    end
  end

  assign acc_rdata = rdata_q;
  assign acc_err   = acc_en && sel == SEL_BAD;

endmodule

// File: rtl/cstub_chk.sv
module cstub_chk #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h4100_00C8
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [31:0]       acc_rdata,
  input logic              acc_err
);

  logic [11:0] c_off;
  logic        c_rd, c_band, c_quiet;

  assign c_off   = acc_addr[11:0];
  assign c_rd    = acc_en && !acc_wr;
  assign c_band  = c_off >= 12'h730 && c_off < 12'h800;
  assign c_quiet = c_off == 12'hF40 || c_off == 12'hF60 || c_off == 12'hF80;

  a_r10_err_needs_access: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> acc_en);

  a_r8_band_no_err: assert property (@(posedge clk) disable iff (rst)
    (acc_en && c_band) |-> !acc_err);

  a_r8_band_reads_done: assert property (@(posedge clk) disable iff (rst)
    (c_rd && c_band) |=> acc_rdata == 32'h0);

  a_r9_quiet_silent: assert property (@(posedge clk) disable iff (rst)
    (acc_en && c_quiet) |-> !acc_err);

  a_r9_quiet_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (c_rd && c_quiet) |=> acc_rdata == 32'h0);

  a_r2_id_const: assert property (@(posedge clk) disable iff (rst)
    (c_rd && c_off == 12'h000) |=> acc_rdata == ID_VALUE);

  a_r4_ctrl_one_bit: assert property (@(posedge clk) disable iff (rst)
    (c_rd && c_off == 12'h100) |=> acc_rdata[31:1] == 31'h0);

  a_r11_no_read_zero: assert property (@(posedge clk) disable iff (rst)
    !c_rd |=> acc_rdata == 32'h0);

endmodule

bind cstub_regbank cstub_chk #(.ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_en    (acc_en),
  .acc_wr    (acc_wr),
  .acc_addr  (acc_addr),
  .acc_rdata (acc_rdata),
  .acc_err   (acc_err)
);

// File: tb/cstub_regbank_bench.sv
`timescale 1ns/1ps
module cstub_regbank_bench;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_en = 1'b0;
  logic          acc_wr = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [31:0]   acc_wdata = '0;
  logic [31:0]   acc_rdata;
  logic          acc_err;

  int n_chk  = 0;
  int n_fail = 0;

  // Behavioural model state
  logic [31:0] m_ctrl, m_aux, m_tag, m_data, m_fs, m_fe, m_type;
  string       pass_tag;

  always #2 clk = ~clk;

  cstub_regbank #(.ADDR_W(AW)) u_cstub_regbank (
    .clk       (clk),
    .rst       (rst),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .acc_err   (acc_err)
  );

  function automatic bit is_band(input logic [11:0] o);
    return o >= 12'h730 && o < 12'h800;
  endfunction

  function automatic bit is_quiet(input logic [11:0] o);
    return o == 12'hF40 || o == 12'hF60 || o == 12'hF80;
  endfunction

  function automatic bit is_bad(input logic [11:0] o);
    if (is_band(o) || is_quiet(o)) return 1'b0;
    case (o)
      12'h000, 12'h004, 12'h100, 12'h104, 12'h108, 12'h10C, 12'hC00, 12'hC04: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string req_of(input logic [11:0] o);
    if (is_band(o))  return "R8";
    if (is_quiet(o)) return "R9";
    case (o)
      12'h000: return "R2";
      12'h004: return "R7";
      12'h100: return "R4";
      12'h104, 12'h108, 12'h10C: return "R5";
      12'hC00, 12'hC04: return "R6";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] fold_of(input logic [31:0] a);
    logic [31:0] f;
    f = {27'd0, a[19:17], 1'b0, a[16]};
    return (f << 18) | (f << 6);
  endfunction

  task automatic model_read(input logic [11:0] o, output logic [31:0] v);
    v = 32'h0;
    case (o)
      12'h000: v = 32'h4100_00C8;
      12'h004: begin m_type = m_type | fold_of(m_aux); v = m_type; end
      12'h100: v = m_ctrl;
      12'h104: v = m_aux;
      12'h108: v = m_tag;
      12'h10C: v = m_data;
      12'hC00: v = m_fs;
      12'hC04: v = m_fe;
      default: v = 32'h0;
    endcase
  endtask

  task automatic model_write(input logic [11:0] o, input logic [31:0] d);
    case (o)
      12'h100: m_ctrl = {31'd0, d[0]};
      12'h104: m_aux  = d;
      12'h108: m_tag  = d;
      12'h10C: m_data = d;
      12'hC00: m_fs   = d;
      12'hC04: m_fe   = d;
      default: ;
    endcase
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_acc(input logic wr, input logic [AW-1:0] addr, input logic [31:0] wd);
    logic [11:0] o;
    logic [31:0] exp_rd;
    logic        exp_err;
    o       = addr[11:0];
    exp_err = is_bad(o);
    exp_rd  = 32'h0;
    if (wr) model_write(o, wd);
    else    model_read(o, exp_rd);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_addr = addr; acc_wdata = wd;
    #1;
    check(acc_err == exp_err, $sformatf("R10 err %s off=%h", pass_tag, o),
          {31'd0, acc_err}, {31'd0, exp_err});
    @(posedge clk);
    #1;
    check(acc_rdata == exp_rd,
          $sformatf("%s %s R11 off=%h wr=%0b", req_of(o), pass_tag, o, wr),
          acc_rdata, exp_rd);
  endtask

  task automatic idle_chk();
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
    @(posedge clk);
    #1;
    check(acc_rdata == 32'h0, "R11 idle", acc_rdata, 32'h0);
  endtask

  function automatic logic [31:0] pat(input int o, input logic [31:0] seed);
    return (32'(o) * 32'h9E37_79B1) ^ seed;
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R11 actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    m_ctrl = 0; m_aux = 32'h0202_0000; m_tag = 0; m_data = 0;
    m_fs = 0; m_fe = 0; m_type = 32'h1C10_0100;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset values over the full offset space (also R2/R7..R10)
    pass_tag = "R1";
    for (int o = 0; o < 4096; o++) do_acc(1'b0, AW'(o), 32'h0);
    idle_chk();

    // R3: writes through an alias with upper bits set
    pass_tag = "R3 write";
    for (int o = 0; o < 4096; o++) do_acc(1'b1, AW'(16'h1000 | o), pat(o, 32'h5A5A_0F0F));
    idle_chk();

    // R3: readback through another alias
    pass_tag = "R3 read";
    for (int o = 0; o < 4096; o++) do_acc(1'b0, AW'(16'hF000 | o), 32'h0);
    idle_chk();

    // R7: sticky type field under chosen auxiliary values
    pass_tag = "R7";
    do_acc(1'b1, 16'h0104, 32'h000F_0000);
    do_acc(1'b0, 16'h0004, 32'h0);
    do_acc(1'b0, 16'h0004, 32'h0);
    do_acc(1'b1, 16'h0104, 32'h0000_0000);
    do_acc(1'b0, 16'h0004, 32'h0);
    do_acc(1'b1, 16'h0004, 32'h0000_0000);
    do_acc(1'b0, 16'h2004, 32'h0);

    // R4: only bit 0 of control kept
    pass_tag = "R4";
    do_acc(1'b1, 16'h0100, 32'hFFFF_FFFE);
    do_acc(1'b0, 16'h0100, 32'h0);
    do_acc(1'b1, 16'h0100, 32'h8000_0001);
    do_acc(1'b0, 16'h0100, 32'h0);

    // R2: identification survives a write
    pass_tag = "R2";
    do_acc(1'b1, 16'h0000, 32'hDEAD_BEEF);
    do_acc(1'b0, 16'h0000, 32'h0);
    idle_chk();

    finish_run();
  end

endmodule